// File: doc/BRIEF.md
# Gate-Drive Shutdown Guard

This block sits between the PWM generators and the gate-drive pins of a motor inverter with a power-factor-correction stage. It takes the six logical phase switch commands of a three-phase bridge and the single PFC switch command. Each command arrives as 1 = switch on. The block drives the gate pins through a per-pin polarity stage. Two active-low shutdown inputs, one for the motor bridge and one for the PFC switch, run through their own glitch filters. A shutdown that is accepted sets a fault flag. While the flag is set, the outputs of that group stay at their inactive level.

A fault flag stays set after the shutdown input returns high. It is removed only when software pulses the clear strobe of that group while the filtered input is high. The polarity of every pin is held in an internal register that software writes. The inactive level of each pin is the inverse of its polarity bit, so a shutdown always turns the switch off, whichever polarity is programmed.

Top module: `gate_kill_guard`

## Requirements
- R1: Each gate output equals its logical command when its polarity bit is 1 (active-high) and the inverse when it is 0 (active-low). Every output is registered: the command sampled at one rising edge appears after that edge. The polarity word `pol_wdata_i` holds the motor phases in bits [5:0] and the PFC pin in bit 6. It is captured on a clock edge where `pol_wr_i` is 1, and it is used for the outputs from the following edge on.
- R2: While the motor fault flag is set, all six motor gate outputs sit at their inactive level (the inverse of their polarity bit), from the edge after the flag rises.
- R3: The motor shutdown acts only on the six motor outputs and the motor flag. The PFC shutdown acts only on the PFC output and the PFC flag. Neither group disturbs the other.
- R4: A shutdown input is accepted only after it has been low for L consecutive clock samples, where L is the effective filter length of its group. A low pulse of L-1 cycles leaves the flag and the outputs unchanged.
- R5: If an input goes low just after an edge and stays low, the fault flag rises after the (L+2)-th following rising edge. The gate outputs reach their inactive level after the (L+3)-th edge. Two of those edges are synchronizer stages.
- R6: The effective filter length is the programmed length `*_filt_len_i`, except that any value below 32 is raised to 32.
- R7: A clear strobe is ignored while the filtered shutdown input of its group is still low.
- R8: With the filtered input high, a clear strobe drops the flag after that edge. The outputs follow the commands again from the next edge.
- R9: While in reset and on leaving it, the motor gates are 0, the PFC gate is 1 and both flags are 0. The polarity register starts with the motor pins active-high and the PFC pin active-low.
- R10: A polarity write made while a group is faulted moves that group's forced-off level to the new inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| motor_pwm_i | input | 6 | Logical phase commands, 1 = switch on (U hi, U lo, V hi, V lo, W hi, W lo) |
| pfc_pwm_i | input | 1 | Logical PFC switch command |
| motor_kill_ni | input | 1 | Motor bridge shutdown request, active low |
| pfc_kill_ni | input | 1 | PFC shutdown request, active low |
| motor_filt_len_i | input | 8 | Motor filter length in clocks (min 32) |
| pfc_filt_len_i | input | 8 | PFC filter length in clocks (min 32) |
| motor_clr_i | input | 1 | Motor fault clear strobe |
| pfc_clr_i | input | 1 | PFC fault clear strobe |
| pol_wr_i | input | 1 | Polarity register write strobe |
| pol_wdata_i | input | 7 | Polarity word, 1 = active-high |
| motor_gate_o | output | 6 | Motor gate pins |
| pfc_gate_o | output | 1 | PFC gate pin |
| motor_fault_o | output | 1 | Motor fault flag |
| pfc_fault_o | output | 1 | PFC fault flag |

## Verification
The bench drives low pulses exactly one cycle shorter than the filter length and exactly equal to it, both at a programmed length and at a value below 32. A filter that counts off by one, or that does not raise small settings to 32, would then trip on the short pulse or miss the long one. It measures the edge on which the flag and the gates change after a shutdown, and would catch a missing or extra pipeline stage. It clears while the input is still low and after it returns high, and a latch that ignores the input level or never releases would be reported. It also faults one group while the other toggles, and rewrites polarity during a fault. A design with crossed kill paths, or with a forced-off level tied to 0, would fail there.

// File: rtl/gk_pkg.sv
package gk_pkg;
  localparam int unsigned MIN_FILT_LEN  = 32;
  localparam int unsigned SYNC_STAGES   = 2;
  localparam int unsigned NUM_GROUPS    = 2;
  localparam logic        MOTOR_POL_RST = 1'b1;
  localparam logic        PFC_POL_RST   = 1'b0;

  typedef enum int unsigned {
    GRP_MOTOR = 0,
    GRP_PFC   = 1
  } grp_e;
endpackage

// File: rtl/gk_glitch_filter.sv
module gk_glitch_filter #(
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned MIN_LEN = 32,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_ni,
  input  logic [LEN_W-1:0] len_i,
  output logic             kill_s_o,
  output logic             trip_o
);
  localparam logic [LEN_W-1:0] MinLen = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] CntMax = '1;

  logic [SYNC_N-1:0] sync_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  eff_len;
  logic              lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-2:0], kill_ni};
  end

  assign lvl = sync_q[SYNC_N-1];

  // short settings are raised to the floor
  assign eff_len = (len_i < MinLen) ? MinLen : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (lvl)            cnt_q <= '0;
    else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign trip_o   = !lvl && (cnt_q == eff_len - 1'b1);
  assign kill_s_o = lvl;
endmodule

// File: rtl/gk_fault_latch.sv
module gk_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic kill_s_i,
  input  logic clr_i,
  output logic fault_o
);
  logic fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  fault_q <= 1'b0;
    else if (trip_i)              fault_q <= 1'b1;
    else if (clr_i && kill_s_i)   fault_q <= 1'b0;
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/gk_out_stage.sv
module gk_out_stage #(
  parameter int unsigned N       = 6,
  parameter logic        RST_POL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] cmd_i,
  input  logic         fault_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] gate_o
);
  logic [N-1:0] gate_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic on;
    assign on = cmd_i[i] & ~fault_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_q[i] <= ~RST_POL;
      else         gate_q[i] <= ~(on ^ pol_i[i]);
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/gate_kill_guard.sv
module gate_kill_guard
  import gk_pkg::*;
#(
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned PHASES = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PHASES-1:0] motor_pwm_i,
  input  logic              pfc_pwm_i,
  input  logic              motor_kill_ni,
  input  logic              pfc_kill_ni,
  input  logic [LEN_W-1:0]  motor_filt_len_i,
  input  logic [LEN_W-1:0]  pfc_filt_len_i,
  input  logic              motor_clr_i,
  input  logic              pfc_clr_i,
  input  logic              pol_wr_i,
  input  logic [PHASES:0]   pol_wdata_i,
  output logic [PHASES-1:0] motor_gate_o,
  output logic              pfc_gate_o,
  output logic              motor_fault_o,
  output logic              pfc_fault_o
);
  localparam int unsigned POL_W = PHASES + 1;
  localparam logic [POL_W-1:0] PolRst = {PFC_POL_RST, {PHASES{MOTOR_POL_RST}}};

  logic [NUM_GROUPS-1:0] kill_n, kill_s, trip, clr, fault;
  logic [LEN_W-1:0]      len [NUM_GROUPS];
  logic [POL_W-1:0]      pol_q;

  assign kill_n[GRP_MOTOR] = motor_kill_ni;
  assign kill_n[GRP_PFC]   = pfc_kill_ni;
  assign len[GRP_MOTOR]    = motor_filt_len_i;
  assign len[GRP_PFC]      = pfc_filt_len_i;
  assign clr[GRP_MOTOR]    = motor_clr_i;
  assign clr[GRP_PFC]      = pfc_clr_i;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    gk_glitch_filter #(
      .LEN_W  (LEN_W),
      .MIN_LEN(MIN_FILT_LEN),
      .SYNC_N (SYNC_STAGES)
    ) i_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .kill_ni (kill_n[g]),
      .len_i   (len[g]),
      .kill_s_o(kill_s[g]),
      .trip_o  (trip[g])
    );

    gk_fault_latch i_latch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trip_i  (trip[g]),
      .kill_s_i(kill_s[g]),
      .clr_i   (clr[g]),
      .fault_o (fault[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pol_q <= PolRst;
    else if (pol_wr_i) pol_q <= pol_wdata_i;
  end

  gk_out_stage #(.N(PHASES), .RST_POL(MOTOR_POL_RST)) i_motor_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (motor_pwm_i),
    .fault_i(fault[GRP_MOTOR]),
    .pol_i  (pol_q[PHASES-1:0]),
    .gate_o (motor_gate_o)
  );

  gk_out_stage #(.N(1), .RST_POL(PFC_POL_RST)) i_pfc_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (pfc_pwm_i),
    .fault_i(fault[GRP_PFC]),
    .pol_i  (pol_q[PHASES]),
    .gate_o (pfc_gate_o)
  );

  assign motor_fault_o = fault[GRP_MOTOR];
  assign pfc_fault_o   = fault[GRP_PFC];
endmodule

// File: rtl/gk_checker.sv
module gk_checker #(
  parameter int unsigned PHASES = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        kill_s,
  input logic [PHASES:0]   pol_q,
  input logic              motor_clr_i,
  input logic              pfc_clr_i,
  input logic [PHASES-1:0] motor_gate_o,
  input logic              pfc_gate_o,
  input logic              motor_fault_o,
  input logic              pfc_fault_o
);
  // R2
  motor_forced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    motor_fault_o |=> (motor_gate_o == ~$past(pol_q[PHASES-1:0])));

  // R3
  pfc_forced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfc_fault_o |=> (pfc_gate_o == ~$past(pol_q[PHASES])));

  // R4
  motor_set_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(motor_fault_o) |-> !$past(kill_s[0]));

  // R4
  pfc_set_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pfc_fault_o) |-> !$past(kill_s[1]));

  // R8
  motor_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(motor_fault_o) |-> ($past(motor_clr_i) && $past(kill_s[0])));

  // R8
  pfc_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pfc_fault_o) |-> ($past(pfc_clr_i) && $past(kill_s[1])));
endmodule

bind gate_kill_guard gk_checker #(.PHASES(PHASES)) i_gk_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .kill_s       (kill_s),
  .pol_q        (pol_q),
  .motor_clr_i  (motor_clr_i),
  .pfc_clr_i    (pfc_clr_i),
  .motor_gate_o (motor_gate_o),
  .pfc_gate_o   (pfc_gate_o),
  .motor_fault_o(motor_fault_o),
  .pfc_fault_o  (pfc_fault_o)
);

// File: tb/test_gate_kill_guard.sv
module test_gate_kill_guard;
  localparam time CLK_P = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] motor_pwm_i = '0;
  logic       pfc_pwm_i = 1'b0;
  logic       motor_kill_ni = 1'b1;
  logic       pfc_kill_ni = 1'b1;
  logic [7:0] motor_filt_len_i = 8'd40;
  logic [7:0] pfc_filt_len_i = 8'd40;
  logic       motor_clr_i = 1'b0;
  logic       pfc_clr_i = 1'b0;
  logic       pol_wr_i = 1'b0;
  logic [6:0] pol_wdata_i = '0;
  logic [5:0] motor_gate_o;
  logic       pfc_gate_o;
  logic       motor_fault_o;
  logic       pfc_fault_o;

  int errors = 0;
  int checks = 0;
  logic [6:0] pol_m = 7'b0111111;

  always #(CLK_P/2) clk_i = ~clk_i;

  gate_kill_guard i_gate_kill_guard (.*);

  function automatic logic [5:0] exp_motor(logic [5:0] cmd, logic fault, logic [5:0] pol);
    return ~((cmd & {6{~fault}}) ^ pol);
  endfunction

  function automatic logic exp_pfc(logic cmd, logic fault, logic pol);
    return ~((cmd & ~fault) ^ pol);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic write_pol(input logic [6:0] v);
    pol_wdata_i = v;
    pol_wr_i = 1'b1;
    step();
    pol_wr_i = 1'b0;
    pol_m = v;
  endtask

  // R4 R6: pulse of given width, then report whether the flag set
  task automatic motor_pulse(input int width, output logic tripped);
    motor_kill_ni = 1'b0;
    step(width);
    motor_kill_ni = 1'b1;
    step(6);
    tripped = motor_fault_o;
  endtask

  task automatic motor_release();
    motor_kill_ni = 1'b1;
    step(3);
    motor_clr_i = 1'b1;
    step();
    motor_clr_i = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic t;
    void'($urandom(32'h5EED_0042));

    // R9: reset state
    #(CLK_P * 3);
    @(negedge clk_i);
    chk(motor_gate_o == 6'h00 && pfc_gate_o == 1'b1, "R9 reset gates",
        {pfc_gate_o, motor_gate_o}, 7'h40);
    rst_ni = 1'b1;
    step();
    chk(!motor_fault_o && !pfc_fault_o, "R9 reset flags", {pfc_fault_o, motor_fault_o}, 0);
    chk(motor_gate_o == 6'h00 && pfc_gate_o == 1'b1, "R9 default polarity idle",
        {pfc_gate_o, motor_gate_o}, 7'h40);

    // R1: random commands and polarity writes
    for (int it = 0; it < 300; it++) begin
      logic [6:0] pol_old;
      logic       wr;
      pol_old = pol_m;
      motor_pwm_i = 6'($urandom);
      pfc_pwm_i = 1'($urandom);
      wr = ($urandom % 8) == 0;
      pol_wdata_i = 7'($urandom);
      pol_wr_i = wr;
      step();
      pol_wr_i = 1'b0;
      if (wr) pol_m = pol_wdata_i;
      chk(motor_gate_o == exp_motor(motor_pwm_i, 1'b0, pol_old[5:0]), "R1 motor polarity",
          motor_gate_o, exp_motor(motor_pwm_i, 1'b0, pol_old[5:0]));
      chk(pfc_gate_o == exp_pfc(pfc_pwm_i, 1'b0, pol_old[6]), "R1 pfc polarity",
          pfc_gate_o, exp_pfc(pfc_pwm_i, 1'b0, pol_old[6]));
    end

    write_pol(7'b0111111);
    motor_pwm_i = 6'h3f;
    pfc_pwm_i = 1'b1;
    motor_filt_len_i = 8'd40;
    step();

    // R5 R2 R3: latency with L=40
    motor_kill_ni = 1'b0;
    step(41);
    chk(!motor_fault_o, "R5 flag not before L+2", motor_fault_o, 0);
    step();
    chk(motor_fault_o, "R5 flag at L+2", motor_fault_o, 1);
    chk(motor_gate_o == 6'h3f, "R5 gates still on at L+2", motor_gate_o, 6'h3f);
    step();
    chk(motor_gate_o == 6'h00, "R2 gates off at L+3", motor_gate_o, 6'h00);
    chk(pfc_gate_o == 1'b0 && !pfc_fault_o, "R3 pfc untouched by motor kill",
        {pfc_fault_o, pfc_gate_o}, 0);
    pfc_pwm_i = 1'b0;
    step();
    chk(pfc_gate_o == 1'b1, "R3 pfc still follows command", pfc_gate_o, 1);
    pfc_pwm_i = 1'b1;

    // R10: polarity write during fault
    write_pol(7'b0000000);
    step();
    chk(motor_gate_o == 6'h3f, "R10 forced level follows new polarity", motor_gate_o, 6'h3f);
    write_pol(7'b0111111);
    step();
    chk(motor_gate_o == 6'h00, "R10 forced level back to active-high inactive",
        motor_gate_o, 6'h00);

    // R7: clear while input still low
    motor_clr_i = 1'b1;
    step();
    motor_clr_i = 1'b0;
    step();
    chk(motor_fault_o && motor_gate_o == 6'h00, "R7 clear ignored while low",
        {motor_fault_o, motor_gate_o}, 7'h40);

    // R8: release then clear
    motor_kill_ni = 1'b1;
    step(3);
    chk(motor_fault_o, "R8 flag held after input high", motor_fault_o, 1);
    motor_clr_i = 1'b1;
    step();
    motor_clr_i = 1'b0;
    chk(!motor_fault_o, "R8 flag cleared", motor_fault_o, 0);
    step();
    chk(motor_gate_o == 6'h3f, "R8 gates resume", motor_gate_o, 6'h3f);

    // R4: L-1 pulse ignored, L pulse accepted
    motor_pulse(39, t);
    chk(!t && motor_gate_o == 6'h3f, "R4 pulse of L-1 ignored", {t, motor_gate_o}, 6'h3f);
    motor_pulse(40, t);
    chk(t, "R4 pulse of L accepted", t, 1);
    motor_release();

    // R6: setting below 32 acts as 32
    motor_filt_len_i = 8'd5;
    motor_pulse(31, t);
    chk(!t, "R6 31-cycle pulse ignored at floor", t, 0);
    motor_pulse(32, t);
    chk(t, "R6 32-cycle pulse accepted at floor", t, 1);
    motor_release();
    chk(!motor_fault_o && motor_gate_o == 6'h3f, "R8 released after floor test",
        {motor_fault_o, motor_gate_o}, 6'h3f);

    // R3: PFC kill leaves motor alone
    pfc_filt_len_i = 8'd33;
    motor_pwm_i = 6'h15;
    pfc_kill_ni = 1'b0;
    step(35);
    chk(pfc_fault_o, "R3 pfc flag at L+2", pfc_fault_o, 1);
    step();
    chk(pfc_gate_o == 1'b1, "R3 pfc gate at inactive (active-low pin)", pfc_gate_o, 1);
    chk(!motor_fault_o && motor_gate_o == 6'h15, "R3 motor untouched by pfc kill",
        {motor_fault_o, motor_gate_o}, 6'h15);
    motor_pwm_i = 6'h2a;
    step();
    chk(motor_gate_o == 6'h2a, "R3 motor still follows command", motor_gate_o, 6'h2a);
    pfc_kill_ni = 1'b1;
    step(3);
    pfc_clr_i = 1'b1;
    step();
    pfc_clr_i = 1'b0;
    step();
    chk(!pfc_fault_o && pfc_gate_o == 1'b0, "R8 pfc resumes",
        {pfc_fault_o, pfc_gate_o}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule